// File: doc/BRIEF.md
# Power-Save Gating Controller

This block sits between a display controller's configuration state and the circuits that must be quieted when the chip enters a deep power-save state. It takes a 3-bit power-save mode code and a few configuration flags. From these it produces grant and halt controls for display-memory traffic and the sequencer, filtered register access strobes, refresh permission, oscillator enables, and output-enable and force values for the panel, CRT and color-DAC outputs.

Two mode codes are deep power-save states. Code 3 also stops memory refresh. Code 4 keeps refresh running. Every other code is treated as normal operation: requests pass through, and pad values pass from the functional logic to the pads. All outputs are registered. A change on any input shows at the outputs one clock edge later and is free of glitches.

Register accesses are tagged with a 2-bit group code: 0 core, 1 look-up table, 2 color DAC, 3 auxiliary.

Top module: `pwrsave_gate`

## Requirements
- R1: In mode 3 or 4, `disp_fetch_gnt`, `cpu_mem_gnt` and `seq_run` are 0. In any other mode (0, 1, 2, 5, 6, 7), the two grants follow their requests and `seq_run` is 1.
- R2: `refresh_ok` is 0 only in mode 3. It is 1 in every other mode, including mode 4.
- R3: In mode 3 or 4 with `lockout_en` = 0, register accesses to group 1 (look-up table) and group 2 (color DAC) are denied, and groups 0 and 3 are granted. Outside modes 3 and 4, every group is granted, whatever the value of `lockout_en`. A grant is issued only when the matching request is present.
- R4: In mode 3 or 4 with `lockout_en` = 1, only group 3 (auxiliary) is granted.
- R5: In mode 3 or 4, `panel_pwr_n` and `bias_en_n` are 1. Otherwise they follow their inputs.
- R6: In mode 3 or 4, `panel_out` is all zeros. `panel_oe` is all zeros when `panel_hiz` = 1 and all ones when `panel_hiz` = 0. Otherwise `panel_oe` is all ones and `panel_out` equals `panel_in`.
- R7: In mode 3 or 4 with `crt_en` = 1, `crt_out` is all zeros and `color_rd_n` and `color_wr_n` are 1. With `crt_en` = 0, or outside these modes, they follow their inputs.
- R8: Bit `osc_sel` of `osc_en` is the only bit that can be 1. That bit is 0 in mode 3 or 4 when `xtal2_mode` = 1, and 1 otherwise.
- R9: Every output is a register with one clock of latency. A synchronous reset sets the grants, `seq_run`, `refresh_ok`, `osc_en`, `panel_oe` and `panel_out` to 0, and sets `panel_pwr_n`, `bias_en_n`, `color_rd_n` and `color_wr_n` to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 3 | Power-save mode code |
| crt_en | input | 1 | CRT output enabled |
| panel_hiz | input | 1 | 1: float panel pads in power-save; 0: drive them low |
| lockout_en | input | 1 | Restrict power-save register access to the auxiliary group |
| xtal2_mode | input | 1 | Two-terminal crystal in use; the selected oscillator may stop |
| osc_sel | input | $clog2(NOSC) | Index of the active oscillator |
| disp_fetch_req | input | 1 | Display fetch request |
| cpu_mem_req | input | 1 | CPU display-memory request |
| io_grp | input | 2 | Register group of the current access |
| io_rd_req | input | 1 | Register read strobe |
| io_wr_req | input | 1 | Register write strobe |
| panel_pwr_n_in | input | 1 | Functional panel power control, active low |
| bias_en_n_in | input | 1 | Functional current-reference enable, active low |
| panel_in | input | PANEL_W | Functional panel data and timing |
| crt_in | input | CRT_W | Functional CRT and DAC signals |
| color_rd_n_in | input | 1 | Functional color-DAC read strobe, active low |
| color_wr_n_in | input | 1 | Functional color-DAC write strobe, active low |
| disp_fetch_gnt | output | 1 | Display fetch grant |
| cpu_mem_gnt | output | 1 | CPU memory grant |
| seq_run | output | 1 | Sequencer run enable |
| refresh_ok | output | 1 | Memory refresh allowed |
| io_rd_gnt | output | 1 | Filtered read strobe |
| io_wr_gnt | output | 1 | Filtered write strobe |
| panel_pwr_n | output | 1 | Panel power control to pad |
| bias_en_n | output | 1 | Current-reference enable to pad |
| panel_oe | output | PANEL_W | Panel pad output enables |
| panel_out | output | PANEL_W | Panel pad values |
| crt_out | output | CRT_W | CRT and DAC pad values |
| color_rd_n | output | 1 | Color-DAC read strobe to pad |
| color_wr_n | output | 1 | Color-DAC write strobe to pad |
| osc_en | output | NOSC | Oscillator enables |

## Verification
The bench exercises every mode code that lies next to the two power-save codes (2, 5, 6, 7). A decoder that checks only the low bits would wrongly gate one of these modes. It separates the two power-save codes through refresh, which catches a design that stops refresh in both. Each register group is tried with the lockout on and off, inside and outside power-save. A filter that ignores the lockout, or applies it in normal mode, grants or denies the wrong group. Further tests cover `crt_en` = 0 in power-save, where a design that forces CRT pads anyway drives zeros, and a one-cycle probe before the clock edge, where an unregistered design shows its new value early.

// File: rtl/pwrsave_pkg.sv
package pwrsave_pkg;
  localparam int MODE_W = 3;
  localparam logic [MODE_W-1:0] MODE_DEEP_NOREF = 3'd3;
  localparam logic [MODE_W-1:0] MODE_DEEP_REF   = 3'd4;

  typedef enum logic [1:0] {
    GRP_CORE = 2'd0,
    GRP_LUT  = 2'd1,
    GRP_DAC  = 2'd2,
    GRP_AUX  = 2'd3
  } reg_grp_e;

  function automatic logic is_deep(input logic [MODE_W-1:0] m);
    return (m == MODE_DEEP_NOREF) || (m == MODE_DEEP_REF);
  endfunction
endpackage

// File: rtl/pwrsave_core_gate.sv
module pwrsave_core_gate
  import pwrsave_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] mode,
  input  logic              disp_fetch_req,
  input  logic              cpu_mem_req,
  output logic              disp_fetch_gnt,
  output logic              cpu_mem_gnt,
  output logic              seq_run,
  output logic              refresh_ok
);
  logic deep;
  assign deep = is_deep(mode);

  always_ff @(posedge clk) begin
    if (rst) begin
      disp_fetch_gnt <= 1'b0;
      cpu_mem_gnt    <= 1'b0;
      seq_run        <= 1'b0;
      refresh_ok     <= 1'b0;
    end else begin
      disp_fetch_gnt <= disp_fetch_req & ~deep;
      cpu_mem_gnt    <= cpu_mem_req & ~deep;
      seq_run        <= ~deep;
      refresh_ok     <= (mode != MODE_DEEP_NOREF);
    end
  end

  // R1
  mem_block_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(mode) == 3'd3 || $past(mode) == 3'd4))
      |-> (!disp_fetch_gnt && !cpu_mem_gnt && !seq_run));

  // R2
  refresh_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mode) == 3'd4) |-> refresh_ok);
endmodule

// File: rtl/pwrsave_io_filter.sv
module pwrsave_io_filter
  import pwrsave_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] mode,
  input  logic              lockout_en,
  input  logic [1:0]        io_grp,
  input  logic              io_rd_req,
  input  logic              io_wr_req,
  output logic              io_rd_gnt,
  output logic              io_wr_gnt
);
  reg_grp_e grp;
  logic     deep;
  logic     allow;

  assign grp  = reg_grp_e'(io_grp);
  assign deep = is_deep(mode);

  always_comb begin
    allow = 1'b1;
    if (deep) begin
      unique case (grp)
        GRP_AUX:  allow = 1'b1;
        GRP_CORE: allow = ~lockout_en;
        GRP_LUT:  allow = 1'b0;
        GRP_DAC:  allow = 1'b0;
        default:  allow = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      io_rd_gnt <= 1'b0;
      io_wr_gnt <= 1'b0;
    end else begin
      io_rd_gnt <= io_rd_req & allow;
      io_wr_gnt <= io_wr_req & allow;
    end
  end

  // R3
  lut_dac_deny_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(mode) == 3'd3 || $past(mode) == 3'd4)
      && ($past(io_grp) == 2'd1 || $past(io_grp) == 2'd2))
      |-> (!io_rd_gnt && !io_wr_gnt));

  // R4
  lockout_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(mode) == 3'd3 || $past(mode) == 3'd4)
      && $past(lockout_en) && $past(io_grp) != 2'd3)
      |-> (!io_rd_gnt && !io_wr_gnt));

  // R3
  normal_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mode) != 3'd3 && $past(mode) != 3'd4)
      |-> (io_rd_gnt == $past(io_rd_req) && io_wr_gnt == $past(io_wr_req)));
endmodule

// File: rtl/pwrsave_pad_force.sv
module pwrsave_pad_force
  import pwrsave_pkg::*;
#(
  parameter int PANEL_W = 24,
  parameter int CRT_W   = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [MODE_W-1:0]  mode,
  input  logic               crt_en,
  input  logic               panel_hiz,
  input  logic               panel_pwr_n_in,
  input  logic               bias_en_n_in,
  input  logic [PANEL_W-1:0] panel_in,
  input  logic [CRT_W-1:0]   crt_in,
  input  logic               color_rd_n_in,
  input  logic               color_wr_n_in,
  output logic               panel_pwr_n,
  output logic               bias_en_n,
  output logic [PANEL_W-1:0] panel_oe,
  output logic [PANEL_W-1:0] panel_out,
  output logic [CRT_W-1:0]   crt_out,
  output logic               color_rd_n,
  output logic               color_wr_n
);
  logic deep;
  logic crt_force;
  assign deep      = is_deep(mode);
  assign crt_force = deep & crt_en;

  // One registered cell per panel pad: enable and value.
  for (genvar i = 0; i < PANEL_W; i++) begin : g_panel
    always_ff @(posedge clk) begin
      if (rst) begin
        panel_oe[i]  <= 1'b0;
        panel_out[i] <= 1'b0;
      end else begin
        panel_oe[i]  <= ~(deep & panel_hiz);
        panel_out[i] <= panel_in[i] & ~deep;
      end
    end
  end

  // One registered cell per CRT/DAC pad.
  for (genvar j = 0; j < CRT_W; j++) begin : g_crt
    always_ff @(posedge clk) begin
      if (rst) crt_out[j] <= 1'b0;
      else     crt_out[j] <= crt_in[j] & ~crt_force;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      panel_pwr_n <= 1'b1;
      bias_en_n   <= 1'b1;
      color_rd_n  <= 1'b1;
      color_wr_n  <= 1'b1;
    end else begin
      panel_pwr_n <= panel_pwr_n_in | deep;
      bias_en_n   <= bias_en_n_in | deep;
      color_rd_n  <= color_rd_n_in | crt_force;
      color_wr_n  <= color_wr_n_in | crt_force;
    end
  end

  // R5
  pwr_high_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(mode) == 3'd3 || $past(mode) == 3'd4))
      |-> (panel_pwr_n && bias_en_n));

  // R6
  panel_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(mode) == 3'd3 || $past(mode) == 3'd4))
      |-> (panel_out == '0 && (panel_oe == '0) == $past(panel_hiz)));

  // R7
  crt_force_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(crt_en) && ($past(mode) == 3'd3 || $past(mode) == 3'd4))
      |-> (crt_out == '0 && color_rd_n && color_wr_n));

  // R7
  crt_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(crt_en)) |-> (crt_out == $past(crt_in)));
endmodule

// File: rtl/pwrsave_osc_ctl.sv
module pwrsave_osc_ctl
  import pwrsave_pkg::*;
#(
  parameter int NOSC      = 2,
  localparam int OSC_SEL_W = $clog2(NOSC)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [MODE_W-1:0]    mode,
  input  logic                 xtal2_mode,
  input  logic [OSC_SEL_W-1:0] osc_sel,
  output logic [NOSC-1:0]      osc_en
);
  logic stop_sel;
  assign stop_sel = is_deep(mode) & xtal2_mode;

  for (genvar k = 0; k < NOSC; k++) begin : g_osc
    always_ff @(posedge clk) begin
      if (rst) osc_en[k] <= 1'b0;
      else     osc_en[k] <= (osc_sel == OSC_SEL_W'(k)) & ~stop_sel;
    end
  end

  // R8
  osc_single_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(osc_en));

  // R8
  osc_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(xtal2_mode) && ($past(mode) == 3'd3 || $past(mode) == 3'd4))
      |-> (osc_en == '0));
endmodule

// File: rtl/pwrsave_gate.sv
module pwrsave_gate
  import pwrsave_pkg::*;
#(
  parameter int PANEL_W = 24,
  parameter int CRT_W   = 8,
  parameter int NOSC    = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [2:0]              mode,
  input  logic                    crt_en,
  input  logic                    panel_hiz,
  input  logic                    lockout_en,
  input  logic                    xtal2_mode,
  input  logic [$clog2(NOSC)-1:0] osc_sel,
  input  logic                    disp_fetch_req,
  input  logic                    cpu_mem_req,
  input  logic [1:0]              io_grp,
  input  logic                    io_rd_req,
  input  logic                    io_wr_req,
  input  logic                    panel_pwr_n_in,
  input  logic                    bias_en_n_in,
  input  logic [PANEL_W-1:0]      panel_in,
  input  logic [CRT_W-1:0]        crt_in,
  input  logic                    color_rd_n_in,
  input  logic                    color_wr_n_in,
  output logic                    disp_fetch_gnt,
  output logic                    cpu_mem_gnt,
  output logic                    seq_run,
  output logic                    refresh_ok,
  output logic                    io_rd_gnt,
  output logic                    io_wr_gnt,
  output logic                    panel_pwr_n,
  output logic                    bias_en_n,
  output logic [PANEL_W-1:0]      panel_oe,
  output logic [PANEL_W-1:0]      panel_out,
  output logic [CRT_W-1:0]        crt_out,
  output logic                    color_rd_n,
  output logic                    color_wr_n,
  output logic [NOSC-1:0]         osc_en
);
  pwrsave_core_gate u_core (
    .clk, .rst, .mode,
    .disp_fetch_req, .cpu_mem_req,
    .disp_fetch_gnt, .cpu_mem_gnt, .seq_run, .refresh_ok
  );

  pwrsave_io_filter u_io (
    .clk, .rst, .mode, .lockout_en, .io_grp,
    .io_rd_req, .io_wr_req, .io_rd_gnt, .io_wr_gnt
  );

  pwrsave_pad_force #(.PANEL_W(PANEL_W), .CRT_W(CRT_W)) u_pad (
    .clk, .rst, .mode, .crt_en, .panel_hiz,
    .panel_pwr_n_in, .bias_en_n_in, .panel_in, .crt_in,
    .color_rd_n_in, .color_wr_n_in,
    .panel_pwr_n, .bias_en_n, .panel_oe, .panel_out, .crt_out,
    .color_rd_n, .color_wr_n
  );

  pwrsave_osc_ctl #(.NOSC(NOSC)) u_osc (
    .clk, .rst, .mode, .xtal2_mode, .osc_sel, .osc_en
  );
endmodule

// File: tb/tb_pwrsave_gate.sv
module tb_pwrsave_gate;
  localparam int CLK_PERIOD = 10;
  localparam int PANEL_W = 24;
  localparam int CRT_W   = 8;
  localparam int NOSC    = 2;
  localparam int NVEC    = 12;

  // Vector: {mode[3], crt_en, panel_hiz, lockout_en, xtal2_mode, io_grp[2],
  //          exp: gnt, seq, refr, io, pwr_n, poe, pout, crt, dac_n, osc0}
  localparam logic [18:0] VEC [NVEC] = '{
    {3'd0, 1'b1, 1'b1, 1'b1, 1'b1, 2'd1, 10'b1111011101},
    {3'd2, 1'b0, 1'b0, 1'b0, 1'b0, 2'd2, 10'b1111011101},
    {3'd3, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 10'b0001110011},
    {3'd3, 1'b0, 1'b1, 1'b0, 1'b1, 2'd1, 10'b0000100100},
    {3'd4, 1'b1, 1'b1, 1'b0, 1'b0, 2'd2, 10'b0010100011},
    {3'd4, 1'b0, 1'b0, 1'b0, 1'b1, 2'd3, 10'b0011110100},
    {3'd4, 1'b1, 1'b0, 1'b1, 1'b0, 2'd0, 10'b0010110011},
    {3'd3, 1'b1, 1'b1, 1'b1, 1'b0, 2'd3, 10'b0001100011},
    {3'd5, 1'b1, 1'b1, 1'b1, 1'b1, 2'd1, 10'b1111011101},
    {3'd7, 1'b1, 1'b1, 1'b1, 1'b1, 2'd2, 10'b1111011101},
    {3'd1, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 10'b1111011101},
    {3'd6, 1'b1, 1'b0, 1'b1, 1'b1, 2'd3, 10'b1111011101}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] mode = 3'd0;
  logic crt_en = 1'b0, panel_hiz = 1'b0, lockout_en = 1'b0, xtal2_mode = 1'b0;
  logic [$clog2(NOSC)-1:0] osc_sel = '0;
  logic disp_fetch_req = 1'b1, cpu_mem_req = 1'b1;
  logic [1:0] io_grp = 2'd0;
  logic io_rd_req = 1'b1, io_wr_req = 1'b1;
  logic panel_pwr_n_in = 1'b0, bias_en_n_in = 1'b0;
  logic [PANEL_W-1:0] panel_in = '1;
  logic [CRT_W-1:0] crt_in = '1;
  logic color_rd_n_in = 1'b0, color_wr_n_in = 1'b0;

  logic disp_fetch_gnt, cpu_mem_gnt, seq_run, refresh_ok;
  logic io_rd_gnt, io_wr_gnt, panel_pwr_n, bias_en_n;
  logic [PANEL_W-1:0] panel_oe, panel_out;
  logic [CRT_W-1:0] crt_out;
  logic color_rd_n, color_wr_n;
  logic [NOSC-1:0] osc_en;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  pwrsave_gate #(.PANEL_W(PANEL_W), .CRT_W(CRT_W), .NOSC(NOSC)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    // Reset state (R9), sampled mid-cycle while reset is held.
    repeat (3) @(negedge clk);
    check("R9 reset grants", {29'd0, disp_fetch_gnt, cpu_mem_gnt, seq_run}, 32'd0);
    check("R9 reset refresh/osc", {29'd0, refresh_ok, osc_en}, 32'd0);
    check("R9 reset panel", {8'd0, panel_oe | panel_out}, 32'd0);
    check("R9 reset high outputs", {28'd0, panel_pwr_n, bias_en_n, color_rd_n, color_wr_n}, 32'hF);
    rst = 1'b0;

    // Vector table (R1..R8)
    for (int v = 0; v < NVEC; v++) begin
      logic [9:0] e;
      {mode, crt_en, panel_hiz, lockout_en, xtal2_mode, io_grp} = VEC[v][18:10];
      e = VEC[v][9:0];
      @(negedge clk);
      check($sformatf("R1 fetch/cpu gnt v%0d", v), {30'd0, disp_fetch_gnt, cpu_mem_gnt}, {30'd0, e[9], e[9]});
      check($sformatf("R1 seq_run v%0d", v), {31'd0, seq_run}, {31'd0, e[8]});
      check($sformatf("R2 refresh v%0d", v), {31'd0, refresh_ok}, {31'd0, e[7]});
      check($sformatf("R3 R4 io gnt v%0d", v), {30'd0, io_rd_gnt, io_wr_gnt}, {30'd0, e[6], e[6]});
      check($sformatf("R5 pwr/bias v%0d", v), {30'd0, panel_pwr_n, bias_en_n}, {30'd0, e[5], e[5]});
      check($sformatf("R6 panel_oe v%0d", v), {8'd0, panel_oe}, {8'd0, {PANEL_W{e[4]}}});
      check($sformatf("R6 panel_out v%0d", v), {8'd0, panel_out}, {8'd0, {PANEL_W{e[3]}}});
      check($sformatf("R7 crt_out v%0d", v), {24'd0, crt_out}, {24'd0, {CRT_W{e[2]}}});
      check($sformatf("R7 color strobes v%0d", v), {30'd0, color_rd_n, color_wr_n}, {30'd0, e[1], e[1]});
      check($sformatf("R8 osc_en v%0d", v), {30'd0, osc_en}, {30'd0, 1'b0, e[0]});
    end

    // R8: second oscillator selected, normal then power-save with crystal
    mode = 3'd0; xtal2_mode = 1'b1; osc_sel = 1'b1;
    @(negedge clk);
    check("R8 osc sel1 normal", {30'd0, osc_en}, 32'd2);
    mode = 3'd4;
    @(negedge clk);
    check("R8 osc sel1 deep xtal", {30'd0, osc_en}, 32'd0);
    xtal2_mode = 1'b0;
    @(negedge clk);
    check("R8 osc sel1 deep no xtal", {30'd0, osc_en}, 32'd2);

    // R3: write-only request to an allowed group grants only the write
    mode = 3'd3; lockout_en = 1'b0; io_grp = 2'd3; io_rd_req = 1'b0; io_wr_req = 1'b1;
    @(negedge clk);
    check("R3 write-only aux", {30'd0, io_rd_gnt, io_wr_gnt}, 32'd1);
    io_rd_req = 1'b1;

    // R6: pattern passthrough in normal mode
    mode = 3'd0; panel_in = 24'hA5C33C; crt_in = 8'h96;
    @(negedge clk);
    check("R6 panel pattern", {8'd0, panel_out}, 32'h00A5C33C);
    check("R7 crt pattern", {24'd0, crt_out}, 32'h96);

    // R7: CRT disabled in power-save passes pattern and strobes
    mode = 3'd3; crt_en = 1'b0; color_rd_n_in = 1'b0; color_wr_n_in = 1'b1;
    @(negedge clk);
    check("R7 crt off deep pass", {24'd0, crt_out}, 32'h96);
    check("R7 strobes pass", {30'd0, color_rd_n, color_wr_n}, 32'd1);

    // R9: one-cycle latency of a mode change
    mode = 3'd0; disp_fetch_req = 1'b1;
    @(negedge clk);
    mode = 3'd3;
    #(CLK_PERIOD/4);
    check("R9 before edge seq_run", {31'd0, seq_run}, 32'd1);
    @(negedge clk);
    check("R9 after edge seq_run", {31'd0, seq_run}, 32'd0);
    check("R9 after edge refresh", {31'd0, refresh_ok}, 32'd0);

    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule